// File: doc/BRIEF.md
# Dual-Mode Register Logic Macrocell Bank

This block is a bank of logic macrocells. Each cell takes one data sum term and one enable/clock sum term from the surrounding array logic. Each cell can be set on its own to one of three behaviours. It can pass the data term straight through. It can hold it in a register clocked by a shared output clock, with the second term as a clock enable. Or it can hold it in a register whose clock is the second term itself. Each of the two terms has its own programmable polarity inversion before it reaches the cell.

A single active-high clear term, shared by every cell, empties all registers at once and needs no clock edge. The pin variant drives each cell through an inverting three-state buffer, which has its own output-enable term for each cell. It gives two feedback values to the array: one from inside the cell, ahead of the buffer, that is always present, and one from the pin, which shows the external level whenever the buffer is off. The buried variant has no pin. A preload port and a readback port give direct access to the register state for diagnostics.

Top module: `regcell_bank`

## Requirements
- R1: In combinational mode (mode code 2'b00, with 2'b11 treated the same) the cell's internal feedback equals the data term XOR its data-inversion bit, with no clock involved.
- R2: In enable mode (mode code 2'b01) the register loads the polarity-adjusted data term on a rising edge of the shared clock only when the polarity-adjusted enable term is 1; otherwise it keeps its value.
- R3: In term-clock mode (mode code 2'b10) the register ignores the shared clock and loads the polarity-adjusted data term on each rising edge of the polarity-adjusted enable term.
- R4: Setting the enable-inversion bit of a cell makes an enable term of 0 act as 1, both as clock enable and as term clock.
- R5: The data-inversion bit of a cell is applied before the register, so the register stores the inverted data term when it is set.
- R6: While the shared clear term is 1, every register reads 0 at once, with no clock edge needed, and it overrides preload and capture.
- R7: With pins present, each pin value is the inverse of the cell's internal feedback, so a cleared register shows 1 at the pin.
- R8: Each pin's drive enable follows that cell's output-enable term.
- R9: The pin feedback equals the driven pin value when the cell's buffer is enabled and the external pin level otherwise; the internal feedback does not depend on the output enable.
- R10: When preload is 1 at a rising edge of the shared clock, every register, in any mode, loads its preload bit regardless of its enable term; the readback port shows the raw register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| outClk | input | 1 | Shared output clock used by enable-mode registers and by preload |
| resetTerm | input | 1 | Shared active-high asynchronous clear term |
| cfgMode | input | 2*CELLS | Per-cell mode, two bits per cell, cell i at bits [2i+1:2i] |
| cfgInvD | input | CELLS | Per-cell data-term inversion |
| cfgInvE | input | CELLS | Per-cell enable/clock-term inversion |
| dTerm | input | CELLS | Data sum terms, one per cell |
| eTerm | input | CELLS | Enable/clock sum terms, one per cell |
| oeTerm | input | CELLS | Per-cell output-enable terms |
| pinIn | input | CELLS | External level seen on each pin when its buffer is off |
| preloadEn | input | 1 | Diagnostic preload strobe, sampled on outClk |
| preloadVal | input | CELLS | Values forced into the registers by preload |
| regState | output | CELLS | Readback of the raw register bits |
| fbCore | output | CELLS | Feedback taken inside the cell, ahead of the pin buffer |
| pinOut | output | CELLS | Value driven onto each pin (inverted cell value) |
| pinOe | output | CELLS | Drive enable for each pin |
| fbPin | output | CELLS | Feedback taken from the pin |

## Verification
The bench builds the bank with four cells and the pin variant. With four cells, one run can mix modes across cells and give each cell a different data, enable and polarity pattern. The pin variant brings the inverting buffer, the per-cell drive enable and the pin feedback path within reach of the checks. Mode changes happen while the shared clock is low, and the term clock is held low on entry to term-clock mode, so no stray edge comes from the clock selection.

// File: rtl/regcell_pkg.sv
package regcell_pkg;

  typedef enum logic [1:0] {
    MODE_COMB     = 2'b00,
    MODE_ENABLE   = 2'b01,
    MODE_TERMCLK  = 2'b10,
    MODE_COMB_ALT = 2'b11
  } cellMode_e;

  // Strobes from control to datapath, one set per cell
  typedef struct packed {
    logic regMode;      // cell value comes from the register
    logic clkFromTerm;  // register clocked by the polarity-adjusted E term
    logic termClk;      // polarity-adjusted E term
    logic capEn;        // capture enable for the data path
    logic preload;      // force preload value on the next shared clock edge
  } cellStrobe_t;

endpackage

// File: rtl/regcell_ctrl.sv
module regcell_ctrl
  import regcell_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic [2*CELLS-1:0] cfgMode,
  input  logic [CELLS-1:0]   cfgInvE,
  input  logic [CELLS-1:0]   eTerm,
  input  logic               preloadEn,
  output cellStrobe_t        strobe [CELLS]
);

  localparam int MODE_W = 2;

  logic [CELLS-1:0] ePol;
  assign ePol = eTerm ^ cfgInvE;

  for (genvar i = 0; i < CELLS; i++) begin : g_ctrl
    cellMode_e cellMode;
    logic      useTerm;

    assign cellMode = cellMode_e'(cfgMode[MODE_W*i +: MODE_W]);
    assign useTerm  = (cellMode == MODE_TERMCLK);

    always_comb begin
      strobe[i].regMode     = (cellMode == MODE_ENABLE) || useTerm;
      // preload always uses the shared clock
      strobe[i].clkFromTerm = useTerm && !preloadEn;
      strobe[i].termClk     = ePol[i];
      // a term-clocked register is always enabled
      strobe[i].capEn       = useTerm || ePol[i];
      strobe[i].preload     = preloadEn;
    end
  end

endmodule

// File: rtl/regcell_dp.sv
module regcell_dp
  import regcell_pkg::*;
#(
  parameter int CELLS   = 4,
  parameter bit HAS_PIN = 1'b1
) (
  input  logic             outClk,
  input  logic             resetTerm,
  input  cellStrobe_t      strobe [CELLS],
  input  logic [CELLS-1:0] dTerm,
  input  logic [CELLS-1:0] cfgInvD,
  input  logic [CELLS-1:0] preloadVal,
  input  logic [CELLS-1:0] oeTerm,
  input  logic [CELLS-1:0] pinIn,
  output logic [CELLS-1:0] regState,
  output logic [CELLS-1:0] fbCore,
  output logic [CELLS-1:0] pinOut,
  output logic [CELLS-1:0] pinOe,
  output logic [CELLS-1:0] fbPin
);

  logic [CELLS-1:0] dPol;
  logic [CELLS-1:0] cellClk;

  assign dPol = dTerm ^ cfgInvD;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic qBit;

    assign cellClk[i] = strobe[i].clkFromTerm ? strobe[i].termClk : outClk;

    always_ff @(posedge cellClk[i] or posedge resetTerm) begin
      if (resetTerm) begin
        qBit <= 1'b0;
      end else if (strobe[i].preload) begin
        qBit <= preloadVal[i];
      end else if (strobe[i].capEn) begin
        qBit <= dPol[i];
      end
    end

    assign regState[i] = qBit;
    assign fbCore[i]   = strobe[i].regMode ? qBit : dPol[i];
  end

  if (HAS_PIN) begin : g_pin
    assign pinOut = ~fbCore;
    assign pinOe  = oeTerm;
    assign fbPin  = (oeTerm & pinOut) | (~oeTerm & pinIn);
  end else begin : g_buried
    assign pinOut = '0;
    assign pinOe  = '0;
    assign fbPin  = '0;
  end

endmodule

// File: rtl/regcell_bank.sv
module regcell_bank
  import regcell_pkg::*;
#(
  parameter int CELLS   = 4,
  parameter bit HAS_PIN = 1'b1
) (
  input  logic               outClk,
  input  logic               resetTerm,
  input  logic [2*CELLS-1:0] cfgMode,
  input  logic [CELLS-1:0]   cfgInvD,
  input  logic [CELLS-1:0]   cfgInvE,
  input  logic [CELLS-1:0]   dTerm,
  input  logic [CELLS-1:0]   eTerm,
  input  logic [CELLS-1:0]   oeTerm,
  input  logic [CELLS-1:0]   pinIn,
  input  logic               preloadEn,
  input  logic [CELLS-1:0]   preloadVal,
  output logic [CELLS-1:0]   regState,
  output logic [CELLS-1:0]   fbCore,
  output logic [CELLS-1:0]   pinOut,
  output logic [CELLS-1:0]   pinOe,
  output logic [CELLS-1:0]   fbPin
);

  cellStrobe_t strobe [CELLS];

  regcell_ctrl #(.CELLS(CELLS)) ctrl_i (
    .cfgMode   (cfgMode),
    .cfgInvE   (cfgInvE),
    .eTerm     (eTerm),
    .preloadEn (preloadEn),
    .strobe    (strobe)
  );

  regcell_dp #(.CELLS(CELLS), .HAS_PIN(HAS_PIN)) dp_i (
    .outClk     (outClk),
    .resetTerm  (resetTerm),
    .strobe     (strobe),
    .dTerm      (dTerm),
    .cfgInvD    (cfgInvD),
    .preloadVal (preloadVal),
    .oeTerm     (oeTerm),
    .pinIn      (pinIn),
    .regState   (regState),
    .fbCore     (fbCore),
    .pinOut     (pinOut),
    .pinOe      (pinOe),
    .fbPin      (fbPin)
  );

endmodule

// File: rtl/regcell_bank_chk.sv
module regcell_bank_chk #(
  parameter int CELLS   = 4,
  parameter bit HAS_PIN = 1'b1
) (
  input logic               outClk,
  input logic               resetTerm,
  input logic [2*CELLS-1:0] cfgMode,
  input logic [CELLS-1:0]   cfgInvD,
  input logic [CELLS-1:0]   cfgInvE,
  input logic [CELLS-1:0]   dTerm,
  input logic [CELLS-1:0]   eTerm,
  input logic [CELLS-1:0]   oeTerm,
  input logic [CELLS-1:0]   pinIn,
  input logic               preloadEn,
  input logic [CELLS-1:0]   preloadVal,
  input logic [CELLS-1:0]   regState,
  input logic [CELLS-1:0]   fbCore,
  input logic [CELLS-1:0]   pinOut,
  input logic [CELLS-1:0]   pinOe,
  input logic [CELLS-1:0]   fbPin
);

  always @(negedge outClk) begin
    // R6
    clear_empties_chk: assert (!resetTerm || regState == '0)
      else $error("clear term active but registers hold %b", regState);
    if (HAS_PIN) begin
      // R7
      pin_inverts_chk: assert (pinOut == ~fbCore)
        else $error("pin %b not inverse of cell %b", pinOut, fbCore);
      // R8
      oe_follows_chk: assert (pinOe == oeTerm)
        else $error("pin enable %b differs from term %b", pinOe, oeTerm);
      // R9
      pin_feedback_chk: assert (fbPin == ((oeTerm & pinOut) | (~oeTerm & pinIn)))
        else $error("pin feedback %b wrong", fbPin);
    end
  end

  // R10
  preload_loads_chk: assert property (@(negedge outClk) disable iff (resetTerm)
    preloadEn |-> regState == preloadVal);

  for (genvar i = 0; i < CELLS; i++) begin : g_chk
    logic [1:0] modeBits;
    logic       ePolBit;
    assign modeBits = cfgMode[2*i +: 2];
    assign ePolBit  = eTerm[i] ^ cfgInvE[i];

    // R2
    hold_when_disabled_chk: assert property (@(negedge outClk) disable iff (resetTerm)
      (modeBits == 2'b01 && !ePolBit && !preloadEn) |-> regState[i] == $past(regState[i]));

    always @(negedge outClk) begin
      // R1
      comb_passthru_chk: assert (!(modeBits == 2'b00 || modeBits == 2'b11)
                                 || fbCore[i] == (dTerm[i] ^ cfgInvD[i]))
        else $error("cell %0d combinational value wrong", i);
    end
  end

endmodule

bind regcell_bank regcell_bank_chk #(.CELLS(CELLS), .HAS_PIN(HAS_PIN)) chk_i (.*);

// File: tb/regcell_bank_tb_top.sv
module regcell_bank_tb_top;

  localparam int CELLS = 4;
  localparam logic [1:0] M_COMB = 2'b00;
  localparam logic [1:0] M_ENA  = 2'b01;
  localparam logic [1:0] M_TCLK = 2'b10;

  logic               outClk = 1'b0;
  logic               resetTerm = 1'b1;
  logic [2*CELLS-1:0] cfgMode = '0;
  logic [CELLS-1:0]   cfgInvD = '0, cfgInvE = '0, dTerm = '0, eTerm = '0;
  logic [CELLS-1:0]   oeTerm = '0, pinIn = '0, preloadVal = '0;
  logic               preloadEn = 1'b0;
  logic [CELLS-1:0]   regState, fbCore, pinOut, pinOe, fbPin;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #5 outClk = ~outClk;

  regcell_bank #(.CELLS(CELLS), .HAS_PIN(1'b1)) dut_i (.*);

  task automatic check(input string req, input logic [CELLS-1:0] act, input logic [CELLS-1:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2*CELLS-1:0] allMode(input logic [1:0] m);
    return {m, m, m, m};
  endfunction

  // drive point: just after the falling edge; sample point: just before the next one
  task automatic toDrive();
    @(negedge outClk);
    #1;
  endtask

  task automatic toSample();
    #8;
  endtask

  task automatic t_reset();
    cfgMode = allMode(M_ENA);
    oeTerm  = '1;
    repeat (3) toDrive();
    toSample();
    check("R6 reset state", regState, 4'b0000);
    check("R7 cleared pin high", pinOut, 4'b1111);
    toDrive();
    resetTerm = 1'b0;
    toSample();
  endtask

  task automatic t_comb();
    toDrive();
    cfgMode = allMode(M_COMB);
    cfgInvD = 4'b0101;
    dTerm   = 4'b0011;
    eTerm   = 4'b0000;
    oeTerm  = 4'b0011;
    pinIn   = 4'b1100;
    toSample();
    check("R1/R5 comb value", fbCore, 4'b0110);
    check("R7 comb pin", pinOut, 4'b1001);
    check("R8 pin enable", pinOe, 4'b0011);
    check("R9 pin feedback", fbPin, 4'b1101);
    toDrive();
    oeTerm = 4'b1100;
    toSample();
    check("R9 core feedback ignores oe", fbCore, 4'b0110);
    check("R8 pin enable second", pinOe, 4'b1100);
  endtask

  task automatic t_enable();
    toDrive();
    resetTerm = 1'b1;
    toDrive();
    resetTerm = 1'b0;
    cfgMode = allMode(M_ENA);
    cfgInvD = 4'b0000;
    cfgInvE = 4'b0000;
    dTerm   = 4'b1010;
    eTerm   = 4'b0011;
    oeTerm  = 4'b1111;
    toSample();
    check("R2 enable capture", regState, 4'b0010);
    toDrive();
    cfgInvE = 4'b1111;
    dTerm   = 4'b0101;
    toSample();
    check("R4 inverted enable", regState, 4'b0110);
    toDrive();
    cfgInvE = 4'b0000;
    cfgInvD = 4'b1111;
    dTerm   = 4'b0000;
    eTerm   = 4'b1000;
    toSample();
    check("R5 inverted data stored", regState, 4'b1110);
    check("R7 registered pin", pinOut, 4'b0001);
  endtask

  task automatic t_termclk();
    toDrive();
    cfgMode = allMode(M_TCLK);
    cfgInvD = 4'b0000;
    cfgInvE = 4'b0000;
    eTerm   = 4'b0000;
    dTerm   = 4'b1111;
    toSample();
    toDrive();
    toSample();
    check("R3 shared clock ignored", regState, 4'b1110);
    eTerm = 4'b0001;
    #1;
    check("R3 term edge capture", regState, 4'b1111);
    dTerm = 4'b0000;
    #1;
    cfgInvE = 4'b0100;
    #1;
    check("R4 inverted term clock", regState, 4'b1011);
    check("R3 core feedback from register", fbCore, 4'b1011);
  endtask

  task automatic t_preload();
    toDrive();
    cfgMode    = {M_TCLK, M_TCLK, M_ENA, M_ENA};
    eTerm      = 4'b0000;
    cfgInvE    = 4'b0000;
    preloadEn  = 1'b1;
    preloadVal = 4'b0101;
    toSample();
    check("R10 preload first", regState, 4'b0101);
    toDrive();
    preloadEn = 1'b0;
    toSample();
    check("R10 preload retained", regState, 4'b0101);
    toDrive();
    preloadEn  = 1'b1;
    preloadVal = 4'b1010;
    toSample();
    check("R10 preload second", regState, 4'b1010);
    toDrive();
    preloadEn = 1'b0;
    toSample();
  endtask

  task automatic t_async_clear();
    toDrive();
    #2;
    resetTerm = 1'b1;
    #1;
    check("R6 clear without clock", regState, 4'b0000);
    toDrive();
    resetTerm = 1'b0;
    toSample();
  endtask

  initial begin
    t_reset();
    t_comb();
    t_enable();
    t_termclk();
    t_preload();
    t_async_clear();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge outClk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

endmodule